// File: doc/BRIEF.md
# Write-Only Two-Wire Control Register Slave

This block is a write-only slave on a two-wire serial bus (I2C-compatible) that loads four control registers of an audio subsystem. A system clock oversamples the bus clock and data lines through two-flop synchronizers. The block finds start and stop conditions and shifts in bits on each bus-clock rising edge. It checks the first byte after a start against a fixed device address, and one bit of that address comes from a strap pin. When the address matches, the block pulls the data line low through an open-drain enable during the ninth clock. The block then takes data bytes until a stop or a new start.

There is no register-pointer byte. Every data byte selects its own target register with its two upper bits and carries the field value in its lower six bits. A master may therefore update any mix of registers in one transfer. Each accepted write gives a one-cycle update strobe together with the 2-bit register index.

The control flow is one state machine with six states. IDLE waits for a start. ADDR shifts in the address byte. On the eighth rising edge ADDR goes to ACK_WAIT on a match, or to IGNORE on a mismatch or a read request. ACK_WAIT waits for the bus clock to fall and then moves to ACK_DRIVE. ACK_DRIVE holds the data line low through the ninth clock and moves to DATA on the next falling edge. DATA shifts in a data byte and goes to ACK_WAIT on its eighth rising edge. IGNORE stays inactive. From any state, a start goes to ADDR and a stop goes to IDLE.

Top module: `audctl_i2c_wslave`

## Requirements
- R1: After reset, all four register outputs are zero (mode field 0 means full shutdown), the data-line pull-down enable is off and the update strobe is low.
- R2: An address byte sent MSB first that equals binary 11111 0 A 0 is acknowledged. A is the level of the strap input, bit 1 of the byte carries A, and bit 0 = 0 means write. The acknowledge is the data line pulled low during the ninth clock.
- R3: An address byte whose bits differ from that pattern, including a bit 1 that does not match the strap, is not acknowledged. All later bytes up to the next start are neither acknowledged nor written.
- R4: An address byte with bit 0 = 1 (read) is treated as a mismatch, as in R3.
- R5: Bits 7:6 of a data byte select the register: 00 mono volume (bits 4:0 stored, output bit 5 reads 0), 01 left volume (bits 5:0), 10 right volume (bits 5:0), 11 mode (bit 5 wake select, bits 3:0 mode, output bit 4 reads 0). No other register changes.
- R6: A mode byte (bits 7:6 = 11) with bit 4 = 1 is acknowledged but leaves the mode register unchanged and gives no strobe.
- R7: Any number of data bytes may follow one matched address, and each one is acknowledged.
- R8: Each accepted data byte gives exactly one single-cycle update strobe, with the written register's index on the index output.
- R9: A start that arrives partway through a byte drops the partial byte without any register change and begins a new address reception.
- R10: After a stop, bits clocked without a new start are neither acknowledged nor written.
- R11: The pull-down enable switches only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Strap that sets address bit 1 |
| sda_oe_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| mono_vol_o | output | 6 | Mono volume register, bit 5 always 0 |
| left_ctl_o | output | 6 | Left volume and effect-enable register |
| right_ctl_o | output | 6 | Right volume and effect-enable register |
| mode_ctl_o | output | 6 | Mode register: bit 5 wake select, bits 3:0 mode, bit 4 always 0 |
| upd_o | output | 1 | One-cycle pulse for each register write |
| upd_idx_o | output | 2 | Index of the register written with upd_o |

## Verification
Matched addresses are sent with both strap levels. Mismatched addresses are sent as a wrong strap bit and as a read request. Comparing the acknowledge and the register contents in these cases shows whether the strap bit and the direction bit are decoded at all. A multi-byte transfer reaches all four selectors with values whose unused bits are set. This shows whether each byte reaches only its own register and whether masked bits are dropped. Three further patterns cover the timing of aborts: a mode byte with the forbidden bit set, a start injected four bits into a data byte, and bits clocked after a stop without a start. These show whether writes happen only for complete, legal bytes inside an open transfer.

// File: rtl/audctl_pkg.sv
package audctl_pkg;
    localparam int BYTE_W  = 8;
    localparam int REG_NUM = 4;
    localparam int IDX_W   = $clog2(REG_NUM);
    localparam int FIELD_W = BYTE_W - IDX_W;
    localparam int CNT_W   = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_WAIT,
        ST_ACK_DRIVE,
        ST_DATA,
        ST_IGNORE
    } bus_state_t;

    // Bits of a data byte's field that each register keeps.
    function automatic logic [FIELD_W-1:0] field_mask(input logic [IDX_W-1:0] idx);
        logic [FIELD_W-1:0] m;
        case (idx)
            2'd0:    m = {1'b0, {(FIELD_W-1){1'b1}}};
            2'd3:    m = {1'b1, 1'b0, {(FIELD_W-2){1'b1}}};
            default: m = '1;
        endcase
        return m;
    endfunction

    // The mode selector rejects a set bit 4.
    function automatic logic field_ok(input logic [IDX_W-1:0] idx,
                                      input logic [FIELD_W-1:0] fld);
        return !(idx == 2'd3 && fld[FIELD_W-2]);
    endfunction
endpackage

// File: rtl/audctl_sync.sv
module audctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;   // index 1 = clock line, 0 = data line

    logic [LINES-1:0] raw;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prv;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-1:0], raw[g]};
        end
        assign cur[g] = chain[STAGES-1];
        assign prv[g] = chain[STAGES];
    end

    assign sda_lvl   = cur[0];
    assign scl_rise  =  cur[1] & ~prv[1];
    assign scl_fall  = ~cur[1] &  prv[1];
    assign start_det =  cur[1] &  prv[1] &  prv[0] & ~cur[0];
    assign stop_det  =  cur[1] &  prv[1] & ~prv[0] &  cur[0];
endmodule

// File: rtl/audctl_fsm.sv
module audctl_fsm
    import audctl_pkg::*;
#(
    parameter logic [5:0] ADDR_PREFIX = 6'b111110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_sel,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_byte
);
    bus_state_t        state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] full_byte;
    logic              last_bit;
    logic              addr_hit;

    assign full_byte = {sh[BYTE_W-2:0], sda_lvl};
    assign last_bit  = (cnt == CNT_W'(BYTE_W-1));
    assign addr_hit  = (full_byte == {ADDR_PREFIX, addr_sel, 1'b0});

    // Next-state decision
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_IGNORE:    nxt = ST_IGNORE;
                ST_ADDR:      if (scl_rise && last_bit) nxt = addr_hit ? ST_ACK_WAIT : ST_IGNORE;
                ST_DATA:      if (scl_rise && last_bit) nxt = ST_ACK_WAIT;
                ST_ACK_WAIT:  if (scl_fall) nxt = ST_ACK_DRIVE;
                ST_ACK_DRIVE: if (scl_fall) nxt = ST_DATA;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // State register and bit datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            sh      <= '0;
            wr_en   <= 1'b0;
            wr_byte <= '0;
        end else begin
            state <= nxt;
            wr_en <= 1'b0;
            if (start_det || (state == ST_ACK_DRIVE && scl_fall)) begin
                cnt <= '0;
            end else if (scl_rise && (state == ST_ADDR || state == ST_DATA)) begin
                sh  <= full_byte;
                cnt <= cnt + 1'b1;
                if (state == ST_DATA && last_bit) begin
                    wr_en   <= 1'b1;
                    wr_byte <= full_byte;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        sda_oe = (state == ST_ACK_DRIVE);
    end
endmodule

// File: rtl/audctl_regs.sv
module audctl_regs
    import audctl_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [BYTE_W-1:0]                 wr_byte,
    output logic [REG_NUM-1:0][FIELD_W-1:0]   fields_o,
    output logic                              upd_o,
    output logic [IDX_W-1:0]                  upd_idx_o
);
    logic [IDX_W-1:0]   wr_idx;
    logic [FIELD_W-1:0] wr_fld;
    logic               wr_ok;

    assign wr_idx = wr_byte[BYTE_W-1 -: IDX_W];
    assign wr_fld = wr_byte[FIELD_W-1:0];
    assign wr_ok  = wr_en && field_ok(wr_idx, wr_fld);

    for (genvar r = 0; r < REG_NUM; r++) begin : g_reg
        logic [FIELD_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_ok && wr_idx == IDX_W'(r))
                q <= wr_fld & field_mask(IDX_W'(r));
        end
        assign fields_o[r] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_o     <= 1'b0;
            upd_idx_o <= '0;
        end else begin
            upd_o <= wr_ok;
            if (wr_ok) upd_idx_o <= wr_idx;
        end
    end
endmodule

// File: rtl/audctl_i2c_wslave.sv
module audctl_i2c_wslave
    import audctl_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] ADDR_PREFIX = 6'b111110
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic               addr_sel_i,
    output logic               sda_oe_o,
    output logic [FIELD_W-1:0] mono_vol_o,
    output logic [FIELD_W-1:0] left_ctl_o,
    output logic [FIELD_W-1:0] right_ctl_o,
    output logic [FIELD_W-1:0] mode_ctl_o,
    output logic               upd_o,
    output logic [IDX_W-1:0]   upd_idx_o
);
    logic                            sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic                            wr_en;
    logic [BYTE_W-1:0]               wr_byte;
    logic [REG_NUM-1:0][FIELD_W-1:0] fields;

    audctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    audctl_fsm #(.ADDR_PREFIX(ADDR_PREFIX)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_sel  (addr_sel_i),
        .sda_oe    (sda_oe_o),
        .wr_en     (wr_en),
        .wr_byte   (wr_byte)
    );

    audctl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_byte   (wr_byte),
        .fields_o  (fields),
        .upd_o     (upd_o),
        .upd_idx_o (upd_idx_o)
    );

    assign mono_vol_o  = fields[0];
    assign left_ctl_o  = fields[1];
    assign right_ctl_o = fields[2];
    assign mode_ctl_o  = fields[3];
endmodule

// File: rtl/audctl_chk.sv
module audctl_chk
    import audctl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               scl_i,
    input logic               sda_oe_o,
    input logic [FIELD_W-1:0] mono_vol_o,
    input logic [FIELD_W-1:0] left_ctl_o,
    input logic [FIELD_W-1:0] right_ctl_o,
    input logic [FIELD_W-1:0] mode_ctl_o,
    input logic               upd_o,
    input logic [IDX_W-1:0]   upd_idx_o
);
    a_r8_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);

    a_r5_mono_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mono_vol_o) |-> (upd_o && upd_idx_o == 2'd0));

    a_r5_left_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(left_ctl_o) |-> (upd_o && upd_idx_o == 2'd1));

    a_r5_right_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(right_ctl_o) |-> (upd_o && upd_idx_o == 2'd2));

    a_r5_mode_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_ctl_o) |-> (upd_o && upd_idx_o == 2'd3));

    a_r6_mode_bit4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o && upd_idx_o == 2'd3) |-> !mode_ctl_o[4]);

    a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);
endmodule

bind audctl_i2c_wslave audctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_oe_o    (sda_oe_o),
    .mono_vol_o  (mono_vol_o),
    .left_ctl_o  (left_ctl_o),
    .right_ctl_o (right_ctl_o),
    .mode_ctl_o  (mode_ctl_o),
    .upd_o       (upd_o),
    .upd_idx_o   (upd_idx_o)
);

// File: tb/test_audctl_i2c_wslave.sv
`timescale 1ns/1ps
module test_audctl_i2c_wslave;
    localparam int Q = 8;   // system clocks per quarter bus period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       addr_sel = 1'b0;
    logic       sda_oe_o;
    logic [5:0] mono_vol_o, left_ctl_o, right_ctl_o, mode_ctl_o;
    logic       upd_o;
    logic [1:0] upd_idx_o;
    wire        sda_bus = sda_m & ~sda_oe_o;

    int n_cmp = 0;
    int n_bad = 0;
    int n_upd = 0;
    int last_idx = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    audctl_i2c_wslave i_audctl_i2c_wslave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_bus),
        .addr_sel_i  (addr_sel),
        .sda_oe_o    (sda_oe_o),
        .mono_vol_o  (mono_vol_o),
        .left_ctl_o  (left_ctl_o),
        .right_ctl_o (right_ctl_o),
        .mode_ctl_o  (mode_ctl_o),
        .upd_o       (upd_o),
        .upd_idx_o   (upd_idx_o)
    );

    always @(negedge clk) begin
        if (rst_n && upd_o) begin
            n_upd++;
            last_idx = upd_idx_o;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic put_bit(input bit b);
        sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    endtask

    task automatic get_ack(output bit a);
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); a = !sda_bus; wq(); scl = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] b, output bit a);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_ack(a);
    endtask

    task automatic t_reset();
        chk("R1 mono", mono_vol_o, 0);
        chk("R1 left", left_ctl_o, 0);
        chk("R1 right", right_ctl_o, 0);
        chk("R1 mode", mode_ctl_o, 0);
        chk("R1 oe", sda_oe_o, 0);
        chk("R1 strobe", upd_o, 0);
    endtask

    task automatic t_strap0();
        bit a; int u0;
        u0 = n_upd;
        addr_sel = 1'b0;
        bus_start();
        put_byte(8'hF8, a);  chk("R2 addr ack strap0", a, 1);
        put_byte(8'h6D, a);  chk("R7 data ack", a, 1);
        bus_stop();
        chk("R5 left value", left_ctl_o, 6'h2D);
        chk("R8 one strobe", n_upd - u0, 1);
        chk("R8 index left", last_idx, 1);
    endtask

    task automatic t_strap1();
        bit a; int u0;
        addr_sel = 1'b1;
        bus_start();
        put_byte(8'hFA, a);  chk("R2 addr ack strap1", a, 1);
        put_byte(8'h95, a);
        bus_stop();
        chk("R5 right value", right_ctl_o, 6'h15);
        u0 = n_upd;
        bus_start();
        put_byte(8'hF8, a);  chk("R3 strap mismatch nack", a, 0);
        put_byte(8'h9F, a);  chk("R3 data nack", a, 0);
        bus_stop();
        chk("R3 right unchanged", right_ctl_o, 6'h15);
        chk("R3 no strobe", n_upd - u0, 0);
        addr_sel = 1'b0;
    endtask

    task automatic t_read();
        bit a; int u0;
        u0 = n_upd;
        bus_start();
        put_byte(8'hF9, a);  chk("R4 read nack", a, 0);
        put_byte(8'h4A, a);  chk("R4 data nack", a, 0);
        bus_stop();
        chk("R4 left unchanged", left_ctl_o, 6'h2D);
        chk("R4 no strobe", n_upd - u0, 0);
    endtask

    task automatic t_multi();
        bit a; int u0; int acks;
        u0 = n_upd; acks = 0;
        bus_start();
        put_byte(8'hF8, a);
        put_byte(8'h3F, a);  acks += a;
        put_byte(8'h47, a);  acks += a;
        put_byte(8'hAA, a);  acks += a;
        put_byte(8'hEB, a);  acks += a;
        bus_stop();
        chk("R7 four acks", acks, 4);
        chk("R5 mono masked", mono_vol_o, 6'h1F);
        chk("R5 left", left_ctl_o, 6'h07);
        chk("R5 right", right_ctl_o, 6'h2A);
        chk("R5 mode", mode_ctl_o, 6'h2B);
        chk("R8 four strobes", n_upd - u0, 4);
        chk("R8 last index", last_idx, 3);
    endtask

    task automatic t_mode_d4();
        bit a; int u0;
        u0 = n_upd;
        bus_start();
        put_byte(8'hF8, a);
        put_byte(8'hD5, a);  chk("R6 bit4 byte acked", a, 1);
        chk("R6 mode unchanged", mode_ctl_o, 6'h2B);
        chk("R6 no strobe", n_upd - u0, 0);
        put_byte(8'hC3, a);
        bus_stop();
        chk("R6 mode written", mode_ctl_o, 6'h03);
        chk("R6 one strobe", n_upd - u0, 1);
    endtask

    task automatic t_abort();
        bit a; int u0;
        u0 = n_upd;
        bus_start();
        put_byte(8'hF8, a);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        put_byte(8'hF8, a);  chk("R9 new address acked", a, 1);
        put_byte(8'h01, a);
        bus_stop();
        chk("R9 left untouched", left_ctl_o, 6'h07);
        chk("R9 mono written", mono_vol_o, 6'h01);
        chk("R9 single strobe", n_upd - u0, 1);
    endtask

    task automatic t_after_stop();
        bit a; int u0;
        u0 = n_upd;
        scl = 1'b0; wq();
        put_byte(8'h4F, a);  chk("R10 no ack after stop", a, 0);
        scl = 1'b1; wq();
        chk("R10 left unchanged", left_ctl_o, 6'h07);
        chk("R10 no strobe", n_upd - u0, 0);
        chk("R11 oe released", sda_oe_o, 0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_strap0();
        t_strap1();
        t_read();
        t_multi();
        t_mode_d4();
        t_abort();
        t_after_stop();
        done = 1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end
endmodule